// File: doc/BRIEF.md
# Mesh Tile Router with Output Walls

This block is the switch of one tile in a two-dimensional mesh network. It has five flit ports: north, south, east, west and local (the tile's own attachment). Every port carries flits in each direction with a valid/ready pair. A packet starts with a header flit that gives the destination column, the destination row and how many body flits follow. The router steers each packet to one output. It resolves X before Y, so a packet travels along its row first and then along its column. When a packet reaches the tile it addresses, it goes out on the local port.

An output belongs to one packet from its header to its last flit. Inputs that compete for a free output are served in round-robin order. Each output can also be set so that one chosen input wins whenever it is asking.

Each output has a wall bit. A wall bit is set to fence off a group of tiles. A packet whose route would leave through a walled output never appears there. The router consumes and discards it flit by flit, raises a sticky violation flag and records which input the packet came from.

The tile's coordinates, the wall bits and the priority settings are loaded through a small write port. Software loads them while the router carries no traffic.

Top module: `meshRouter`

## Requirements
- R1: Routing is X first. If the destination X is greater than the local X the packet leaves east; if it is smaller, west. Only when the X values match is Y compared: a greater Y leaves north, a smaller Y leaves south.
- R2: A packet whose destination X and Y both equal the local coordinates leaves on the local port.
- R3: Round-robin arbitration. After an output is released, its search pointer moves to the input just after the one that was last granted. The pointer moves only when that input's packet completes. When the output is free, the first requesting input found from the pointer upward (wrapping) is granted.
- R4: Once granted, an output carries only the flits of that packet, in order and with no interleaving, until the packet's final flit has passed. Every flit sent is delivered.
- R5: Priority mode. When an output's priority-enable bit is set and the selected priority input is requesting that output, that input is granted ahead of the rotating order.
- R6: A flit moves on an output only when valid and ready are both high. While ready is low, the output holds its valid and data steady, the sending input sees ready low, and no flit is lost.
- R7: A packet whose route is an output with its wall bit set is consumed and dropped. None of its flits appears on any output, the violation flag goes high and stays high until reset, and violPort records the input it came from. Other traffic keeps flowing.
- R8: Header layout: bits [3:0] destination X, [7:4] destination Y, [12:8] body-flit count N. The packet is the header plus N flits, N from 0 to 31. The output is released after the last of them.
- R9: Configuration writes use cfgWe with cfgAddr. Address 0 loads local X from data[3:0] and local Y from data[7:4]. Address 1 loads the wall bits, where bit p walls port p. Address 2 loads the priority-enable bits from data[4:0] (bit p for output p) and the priority input number from data[7:5]. Port numbers are north 0, south 1, east 2, west 3, local 4.
- R10: During and directly after reset, no output is valid, no input is ready and the violation flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration register select |
| cfgData | input | 8 | Configuration write data |
| inValid | input | 5 | Per-input flit valid, indexed by port number |
| inData | input | 5x16 | Per-input flit |
| inReady | output | 5 | Per-input ready |
| outValid | output | 5 | Per-output flit valid |
| outData | output | 5x16 | Per-output flit |
| outReady | input | 5 | Per-output ready from the neighbour |
| violation | output | 1 | Sticky wall-violation flag |
| violPort | output | 3 | Input number of the last walled packet |

## Verification
The assertions run on every cycle and check three things:
- An output has at most one forwarding input, and its owner is held until release.
- A stalled output keeps its valid and data.
- A dropping input never drives an output, and the violation flag never clears by itself.

Other behaviours cannot be seen from any single cycle; only the bench's scenarios show them:
- the routing direction for each coordinate relation;
- the rotating grant order across successive contentions;
- the priority override;
- the full delivery of zero-length and 31-body packets;
- the silent disposal of walled packets while other traffic still passes.

// File: rtl/meshRtrPkg.sv
package meshRtrPkg;
  localparam int NPORT = 5;
  localparam int PW = 3;

  localparam logic [PW-1:0] PORT_N = 3'd0;
  localparam logic [PW-1:0] PORT_S = 3'd1;
  localparam logic [PW-1:0] PORT_E = 3'd2;
  localparam logic [PW-1:0] PORT_W = 3'd3;
  localparam logic [PW-1:0] PORT_L = 3'd4;

  typedef enum logic [1:0] {IN_IDLE, IN_FWD, IN_DROP} inMode_t;

  // strobes from control to the crossbar datapath
  typedef struct packed {
    logic [NPORT-1:0]         ownValid;
    logic [NPORT-1:0][PW-1:0] ownIdx;
    logic [NPORT-1:0]         fwdEn;
    logic [NPORT-1:0][PW-1:0] fwdOut;
    logic [NPORT-1:0]         drop;
  } xbarCtl_t;
endpackage

// File: rtl/rrArb.sv
module rrArb
  import meshRtrPkg::*;
#(
  parameter int N = NPORT
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  req,
  input  logic          prioEn,
  input  logic [PW-1:0] prioSel,
  input  logic          relOwner,
  output logic          ownValid,
  output logic [PW-1:0] ownIdx,
  output logic          grantNow,
  output logic [PW-1:0] grantIdx
);
  logic [PW-1:0] ptr;

  always_comb begin
    logic found;
    int idx;
    found = 1'b0;
    grantIdx = ptr;
    for (int k = 0; k < N; k++) begin
      idx = int'(ptr) + k;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        grantIdx = PW'(idx);
        found = 1'b1;
      end
    end
    if (prioEn && (int'(prioSel) < N) && req[prioSel]) grantIdx = prioSel;
    grantNow = !ownValid && found;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownValid <= 1'b0;
      ownIdx   <= '0;
      ptr      <= '0;
    end else if (relOwner) begin
      ownValid <= 1'b0;
      ptr      <= (ownIdx == PW'(N-1)) ? '0 : ownIdx + 1'b1;
    end else if (grantNow) begin
      ownValid <= 1'b1;
      ownIdx   <= grantIdx;
    end
  end

  // R3
  grant_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantNow |-> req[grantIdx]);

  // R4
  hold_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ownValid && !relOwner) |=> (ownValid && $stable(ownIdx)));
endmodule

// File: rtl/rtrCtrl.sv
module rtrCtrl
  import meshRtrPkg::*;
#(
  parameter int CW    = 4,
  parameter int LW    = 5,
  parameter int CFG_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgWe,
  input  logic [1:0]                    cfgAddr,
  input  logic [CFG_W-1:0]              cfgData,
  input  logic [NPORT-1:0]              inValid,
  input  logic [NPORT-1:0][CW-1:0]      hdrX,
  input  logic [NPORT-1:0][CW-1:0]      hdrY,
  input  logic [NPORT-1:0][LW-1:0]      hdrLen,
  input  logic [NPORT-1:0]              inFire,
  output xbarCtl_t                      ctl,
  output logic                          violation,
  output logic [PW-1:0]                 violPort
);
  logic [CW-1:0]    locX, locY;
  logic [NPORT-1:0] wall, prioEn;
  logic [PW-1:0]    prioSel;

  inMode_t       mode   [NPORT];
  logic [PW-1:0] fwdOut [NPORT];
  logic [LW:0]   remain [NPORT];
  logic [PW-1:0] routeOf[NPORT];

  logic [NPORT-1:0] walled, headReq, dropNow, granted, lastFire;
  logic [NPORT-1:0] reqTo   [NPORT];
  logic             ownValid[NPORT];
  logic [PW-1:0]    ownIdx  [NPORT];
  logic             grantNow[NPORT];
  logic [PW-1:0]    grantIdx[NPORT];
  logic             relOwner[NPORT];
  logic             violHit;
  logic [PW-1:0]    violIdx;

  function automatic logic [PW-1:0] steer(input logic [CW-1:0] dx, input logic [CW-1:0] dy,
                                          input logic [CW-1:0] lx, input logic [CW-1:0] ly);
    if (dx > lx) return PORT_E;
    if (dx < lx) return PORT_W;
    if (dy > ly) return PORT_N;
    if (dy < ly) return PORT_S;
    return PORT_L;
  endfunction

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      routeOf[i]  = steer(hdrX[i], hdrY[i], locX, locY);
      walled[i]   = wall[routeOf[i]];
      headReq[i]  = (mode[i] == IN_IDLE) && inValid[i];
      dropNow[i]  = (headReq[i] && walled[i]) || (mode[i] == IN_DROP);
      lastFire[i] = (mode[i] == IN_FWD) && inFire[i] && (remain[i] == 1);
    end
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        reqTo[o][i] = headReq[i] && !walled[i] && (routeOf[i] == PW'(o));
  end

  always_comb begin
    granted = '0;
    for (int o = 0; o < NPORT; o++) begin
      relOwner[o] = ownValid[o] && lastFire[ownIdx[o]];
      if (grantNow[o]) granted[grantIdx[o]] = 1'b1;
    end
    violHit = 1'b0;
    violIdx = '0;
    for (int i = NPORT-1; i >= 0; i--) begin
      if (headReq[i] && walled[i] && inFire[i]) begin
        violHit = 1'b1;
        violIdx = PW'(i);
      end
    end
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_arb
    rrArb #(.N(NPORT)) u_arb (
      .clk     (clk),
      .rstN    (rstN),
      .req     (reqTo[g]),
      .prioEn  (prioEn[g]),
      .prioSel (prioSel),
      .relOwner(relOwner[g]),
      .ownValid(ownValid[g]),
      .ownIdx  (ownIdx[g]),
      .grantNow(grantNow[g]),
      .grantIdx(grantIdx[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locX    <= '0;
      locY    <= '0;
      wall    <= '0;
      prioEn  <= '0;
      prioSel <= '0;
    end else if (cfgWe) begin
      case (cfgAddr)
        2'd0: begin
          locX <= cfgData[CW-1:0];
          locY <= cfgData[2*CW-1:CW];
        end
        2'd1: wall <= cfgData[NPORT-1:0];
        2'd2: begin
          prioEn  <= cfgData[NPORT-1:0];
          prioSel <= cfgData[CFG_W-1:CFG_W-PW];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      violation <= 1'b0;
      violPort  <= '0;
    end else if (violHit) begin
      violation <= 1'b1;
      violPort  <= violIdx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NPORT; i++) begin
        mode[i]   <= IN_IDLE;
        fwdOut[i] <= '0;
        remain[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NPORT; i++) begin
        case (mode[i])
          IN_IDLE: begin
            if (granted[i]) begin
              mode[i]   <= IN_FWD;
              fwdOut[i] <= routeOf[i];
              remain[i] <= (LW+1)'(hdrLen[i]) + 1'b1;
            end else if (inFire[i] && (hdrLen[i] != '0)) begin
              mode[i]   <= IN_DROP;
              remain[i] <= (LW+1)'(hdrLen[i]);
            end
          end
          IN_FWD, IN_DROP: begin
            if (inFire[i]) begin
              if (remain[i] == 1) mode[i] <= IN_IDLE;
              remain[i] <= remain[i] - 1'b1;
            end
          end
          default: mode[i] <= IN_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NPORT; k++) begin
      ctl.ownValid[k] = ownValid[k];
      ctl.ownIdx[k]   = ownIdx[k];
      ctl.fwdEn[k]    = (mode[k] == IN_FWD);
      ctl.fwdOut[k]   = fwdOut[k];
      ctl.drop[k]     = dropNow[k];
    end
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_chk
    logic [NPORT-1:0] users;
    always_comb
      for (int i = 0; i < NPORT; i++)
        users[i] = (mode[i] == IN_FWD) && (fwdOut[i] == PW'(g));

    // R4
    one_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($countones(users) <= 1) && ((users == '0) || ownValid[g]));

    // R8
    remain_live_chk: assert property (@(posedge clk) disable iff (!rstN)
      (mode[g] != IN_IDLE) |-> (remain[g] != '0));
  end

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    violation |=> violation);
endmodule

// File: rtl/rtrPath.sv
module rtrPath
  import meshRtrPkg::*;
#(
  parameter int FLIT_W = 16,
  parameter int CW     = 4,
  parameter int LW     = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  xbarCtl_t                      ctl,
  input  logic [NPORT-1:0]              inValid,
  input  logic [NPORT-1:0][FLIT_W-1:0]  inData,
  input  logic [NPORT-1:0]              outReady,
  output logic [NPORT-1:0]              outValid,
  output logic [NPORT-1:0][FLIT_W-1:0]  outData,
  output logic [NPORT-1:0]              inReady,
  output logic [NPORT-1:0]              inFire,
  output logic [NPORT-1:0][CW-1:0]      hdrX,
  output logic [NPORT-1:0][CW-1:0]      hdrY,
  output logic [NPORT-1:0][LW-1:0]      hdrLen
);
  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      outValid[o] = ctl.ownValid[o] && inValid[ctl.ownIdx[o]];
      outData[o]  = inData[ctl.ownIdx[o]];
    end
    for (int i = 0; i < NPORT; i++) begin
      inReady[i] = ctl.drop[i] || (ctl.fwdEn[i] && outReady[ctl.fwdOut[i]]);
      inFire[i]  = inValid[i] && inReady[i];
      hdrX[i]    = inData[i][CW-1:0];
      hdrY[i]    = inData[i][2*CW-1:CW];
      hdrLen[i]  = inData[i][2*CW+LW-1:2*CW];
    end
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_chk
    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (outValid[g] && !outReady[g]) |=> (outValid[g] && $stable(outData[g])));

    // R7
    drop_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      outValid[g] |-> !ctl.drop[ctl.ownIdx[g]]);
  end
endmodule

// File: rtl/meshRouter.sv
module meshRouter
  import meshRtrPkg::*;
#(
  parameter int FLIT_W = 16,
  parameter int CW     = 4,
  parameter int LW     = 5
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  cfgWe,
  input  logic [1:0]                            cfgAddr,
  input  logic [((2*CW > 8) ? 2*CW : 8)-1:0]    cfgData,
  input  logic [NPORT-1:0]                      inValid,
  input  logic [NPORT-1:0][FLIT_W-1:0]          inData,
  output logic [NPORT-1:0]                      inReady,
  output logic [NPORT-1:0]                      outValid,
  output logic [NPORT-1:0][FLIT_W-1:0]          outData,
  input  logic [NPORT-1:0]                      outReady,
  output logic                                  violation,
  output logic [PW-1:0]                         violPort
);
  localparam int CFG_W = (2*CW > 8) ? 2*CW : 8;

  xbarCtl_t                  ctl;
  logic [NPORT-1:0]          inFire;
  logic [NPORT-1:0][CW-1:0]  hdrX, hdrY;
  logic [NPORT-1:0][LW-1:0]  hdrLen;

  rtrCtrl #(.CW(CW), .LW(LW), .CFG_W(CFG_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgData  (cfgData),
    .inValid  (inValid),
    .hdrX     (hdrX),
    .hdrY     (hdrY),
    .hdrLen   (hdrLen),
    .inFire   (inFire),
    .ctl      (ctl),
    .violation(violation),
    .violPort (violPort)
  );

  rtrPath #(.FLIT_W(FLIT_W), .CW(CW), .LW(LW)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .inValid (inValid),
    .inData  (inData),
    .outReady(outReady),
    .outValid(outValid),
    .outData (outData),
    .inReady (inReady),
    .inFire  (inFire),
    .hdrX    (hdrX),
    .hdrY    (hdrY),
    .hdrLen  (hdrLen)
  );
endmodule

// File: tb/meshRouter_bench.sv
module meshRouter_bench;
  localparam int PN = 0, PS = 1, PE = 2, PWST = 3, PL = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rstN;
  logic            cfgWe;
  logic [1:0]      cfgAddr;
  logic [7:0]      cfgData;
  logic [4:0]      inValid;
  logic [4:0][15:0] inData;
  logic [4:0]      inReady;
  logic [4:0]      outValid;
  logic [4:0][15:0] outData;
  logic [4:0]      outReady;
  logic            violation;
  logic [2:0]      violPort;

  meshRouter u_meshRouter (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outReady(outReady),
    .violation(violation), .violPort(violPort)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string curReq = "R10";
  logic [15:0] expQ [5][$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // header: [3:0] X, [7:4] Y, [12:8] body count
  function automatic logic [15:0] mkFlit(int dx, int dy, int n, int tag, int k);
    if (k == 0) return {3'b000, 5'(n), 4'(dy), 4'(dx)};
    return {8'(tag), 8'(k)};
  endfunction

  task automatic pushExp(int o, int dx, int dy, int n, int tag);
    for (int k = 0; k <= n; k++) expQ[o].push_back(mkFlit(dx, dy, n, tag, k));
  endtask

  task automatic drivePkt(int p, int dx, int dy, int n, int tag);
    for (int k = 0; k <= n; k++) begin
      @(negedge clk);
      inValid[p] = 1'b1;
      inData[p]  = mkFlit(dx, dy, n, tag, k);
      #4;
      while (!inReady[p]) begin
        @(negedge clk);
        #4;
      end
    end
    @(negedge clk);
    inValid[p] = 1'b0;
  endtask

  task automatic cfgWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic drain();
    int t = 0;
    while ((expQ[0].size() + expQ[1].size() + expQ[2].size() + expQ[3].size() + expQ[4].size()) != 0
           && t < 2000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    for (int o = 0; o < 5; o++)
      chk(expQ[o].size() == 0, "R4", $sformatf("flits missing on port %0d", o), expQ[o].size(), 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #4;
    if (rstN) begin
      for (int o = 0; o < 5; o++) begin
        if (outValid[o] && outReady[o]) begin
          if (expQ[o].size() == 0) begin
            chk(1'b0, curReq, $sformatf("unexpected flit on port %0d", o), outData[o], 0);
          end else begin
            logic [15:0] e;
            e = expQ[o].pop_front();
            chk(outData[o] == e, curReq, $sformatf("flit on port %0d", o), outData[o], e);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cfgWe = 1'b0; cfgAddr = '0; cfgData = '0;
    inValid = '0; inData = '0; outReady = 5'h1F;
    repeat (3) @(negedge clk);
    #4;
    chk(outValid == 5'h0, "R10", "outValid in reset", outValid, 0);
    chk(inReady == 5'h0, "R10", "inReady in reset", inReady, 0);
    chk(violation == 1'b0, "R10", "violation in reset", violation, 0);
    @(negedge clk);
    rstN = 1'b1;
    #4;
    chk(outValid == 5'h0 && inReady == 5'h0, "R10", "idle after reset", {outValid, inReady}, 0);

    // R9: local coordinates (2,2)
    cfgWrite(2'd0, 8'h22);

    curReq = "R2";
    pushExp(PL, 2, 2, 2, 8'h01);
    drivePkt(PN, 2, 2, 2, 8'h01);
    drain();

    curReq = "R1";
    pushExp(PE, 4, 0, 1, 8'h02);
    pushExp(PWST, 0, 3, 2, 8'h03);
    pushExp(PN, 2, 5, 1, 8'h04);
    pushExp(PS, 2, 0, 0, 8'h05);
    fork
      drivePkt(PL, 4, 0, 1, 8'h02);
      drivePkt(PS, 0, 3, 2, 8'h03);
      drivePkt(PE, 2, 5, 1, 8'h04);
      drivePkt(PWST, 2, 0, 0, 8'h05);
    join
    drain();

    curReq = "R8";
    pushExp(PL, 2, 2, 0, 8'h06);
    pushExp(PE, 7, 2, 31, 8'h07);
    fork
      drivePkt(PS, 2, 2, 0, 8'h06);
      drivePkt(PWST, 7, 2, 31, 8'h07);
    join
    drain();

    // R3: local pointer sits at 2, so order east, north, south
    curReq = "R3";
    pushExp(PL, 2, 2, 3, 8'h12);
    pushExp(PL, 2, 2, 3, 8'h10);
    pushExp(PL, 2, 2, 3, 8'h11);
    fork
      drivePkt(PN, 2, 2, 3, 8'h10);
      drivePkt(PS, 2, 2, 3, 8'h11);
      drivePkt(PE, 2, 2, 3, 8'h12);
    join
    drain();
    // pointer now 2: west before north
    pushExp(PL, 2, 2, 2, 8'h13);
    pushExp(PL, 2, 2, 2, 8'h14);
    fork
      drivePkt(PN, 2, 2, 2, 8'h14);
      drivePkt(PWST, 2, 2, 2, 8'h13);
    join
    drain();

    // R5: priority on local output, priority input east; pointer favours south
    curReq = "R5";
    cfgWrite(2'd2, 8'h50);
    pushExp(PL, 2, 2, 1, 8'h21);
    pushExp(PL, 2, 2, 1, 8'h20);
    fork
      drivePkt(PS, 2, 2, 1, 8'h20);
      drivePkt(PE, 2, 2, 1, 8'h21);
    join
    drain();
    cfgWrite(2'd2, 8'h00);

    curReq = "R6";
    @(negedge clk);
    outReady[PE] = 1'b0;
    pushExp(PE, 5, 2, 3, 8'h30);
    fork
      drivePkt(PL, 5, 2, 3, 8'h30);
      begin
        repeat (4) @(negedge clk);
        #4;
        chk(outValid[PE] == 1'b1, "R6", "valid held while stalled", outValid[PE], 1);
        chk(outData[PE] == mkFlit(5, 2, 3, 8'h30, 0), "R6", "header held while stalled",
            outData[PE], mkFlit(5, 2, 3, 8'h30, 0));
        chk(inReady[PL] == 1'b0, "R6", "source stalled", inReady[PL], 0);
        for (int k = 0; k < 8; k++) begin
          @(negedge clk);
          outReady[PE] = (k % 2 == 0);
        end
        @(negedge clk);
        outReady[PE] = 1'b1;
      end
    join
    drain();

    // R9: move tile to (5,5), packet to (5,5) goes local
    curReq = "R9";
    cfgWrite(2'd0, 8'h55);
    pushExp(PL, 5, 5, 1, 8'h50);
    drivePkt(PN, 5, 5, 1, 8'h50);
    drain();
    cfgWrite(2'd0, 8'h22);

    // R7: wall east (bit 2)
    curReq = "R7";
    cfgWrite(2'd1, 8'h04);
    drivePkt(PL, 5, 2, 3, 8'h40);
    @(negedge clk);
    #4;
    chk(violation == 1'b1, "R7", "violation flag", violation, 1);
    chk(violPort == 3'(PL), "R7", "violating input", violPort, PL);
    pushExp(PN, 2, 5, 1, 8'h41);
    drivePkt(PWST, 2, 5, 1, 8'h41);
    drain();
    drivePkt(PS, 6, 1, 0, 8'h42);
    @(negedge clk);
    #4;
    chk(violPort == 3'(PS), "R7", "violating input header-only", violPort, PS);
    cfgWrite(2'd1, 8'h00);
    pushExp(PE, 5, 2, 2, 8'h43);
    drivePkt(PL, 5, 2, 2, 8'h43);
    drain();
    chk(violation == 1'b1, "R7", "flag sticky", violation, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule